// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the system's interrupt wiring. Each channel presents a one-cycle fire strobe and a set of configuration bits: channel enable, level or edge type, a line number, a message-enable bit and a 64-bit message word. A fired channel either drives an interrupt line (held for level type, a one-cycle pulse for edge type) or, when message delivery is chosen, queues a 32-bit memory-write request. Level-type interrupts are recorded in a status vector that software clears by writing ones.

Two lines are shared with an external interval timer and a real-time clock. Outside legacy mode the router passes those two external inputs through to lines 0 and 8. In legacy mode channels 0 and 1 take over lines 0 and 8, the external inputs are kept off those lines, and the external interval timer's enable output is dropped. Lines numbered 16 and above are active low. The message request leaves through a valid/ready port. While `msg_valid` is high and `msg_ready` is low, the request is held unchanged. Further fires of channels that are waiting are merged into their pending request. Waiting channels are served lowest index first.

Top module: `irq_router`

## Requirements
- R1: After reset the status vector is all zero, lines below 16 read 0, lines 16 and above read 1, `msg_valid` is 0 and `pit_en_o` is 1.
- R2: A fire of an enabled, level-type, wire-delivered channel sets its status bit and asserts its line from the following cycle until the bit is cleared.
- R3: A fire of an edge-type channel clears its status bit and asserts its line for exactly one cycle.
- R4: A cycle with `clr_we` high clears every status bit whose `clr_mask` bit is 1 and deasserts the matching lines; mask bits of 0 leave status and lines unchanged.
- R5: A line numbered 16 or higher is driven 0 when asserted and 1 when idle; lower lines are driven 1 when asserted.
- R6: With `legacy_on` high, channel 0 drives line 0 and channel 1 drives line 8 whatever their route field; other channels, and channels 0 and 1 with legacy off, use `ch_route`.
- R7: A fire of a channel with `ch_msg_en` set produces a request with `msg_addr` = bits 63:32 and `msg_data` = bits 31:0 of its `ch_msg_word`; it drives no line and sets no status bit.
- R8: While `msg_valid` is high and `msg_ready` low, `msg_valid`, `msg_addr` and `msg_data` stay unchanged; repeated fires of a waiting channel yield one request; simultaneous requests are issued lowest channel first.
- R9: A channel with `ch_en` low, or any channel while `glb_en` is low, has its status bit cleared and line deasserted the next cycle, and its fires are ignored.
- R10: A 0-to-1 change of a channel's `ch_msg_en` clears its status bit and deasserts its line.
- R11: With legacy off, line 0 follows `ext_pit_in` and line 8 follows `ext_rtc_in`, each one cycle later.
- R12: `pit_en_o` equals the inverse of `legacy_on` one cycle later; in legacy mode the external inputs do not reach lines 0 and 8, and on leaving it line 8 returns to the current external clock level.
- R13: When a level fire and a status clear hit the same channel in the same cycle, the fire wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global interrupt enable |
| legacy_on | input | 1 | Legacy replacement mode |
| ch_en | input | N_CH | Per-channel enable |
| ch_level | input | N_CH | 1 = level type, 0 = edge type |
| ch_msg_en | input | N_CH | 1 = deliver by memory-write message |
| ch_route | input | N_CH x ROUTE_W | Per-channel line number |
| ch_msg_word | input | N_CH x 64 | Message address (63:32) and data (31:0) |
| fire | input | N_CH | One-cycle fire strobes |
| clr_we | input | 1 | Status clear write strobe |
| clr_mask | input | N_CH | Write-one-to-clear mask |
| ext_pit_in | input | 1 | External interval timer interrupt |
| ext_rtc_in | input | 1 | External real-time clock interrupt |
| irq_o | output | N_LINES | Interrupt lines, polarity per line number |
| status_o | output | N_CH | Interrupt status vector |
| pit_en_o | output | 1 | Enable for the external interval timer |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 32 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The collision that matters is a level fire and a write-one-to-clear on the same channel in the same cycle. The bench first sets the bit, then raises `fire` and `clr_we` with that channel's mask bit together before one edge, and expects the status bit and line still set afterwards. A second collision is fires of a channel whose request is already pending while the output port is stalled. It is judged by counting the requests that appear once `msg_ready` rises, which must be exactly one for that channel.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LEGACY_LINE_A = 0;
  localparam int LEGACY_LINE_B = 8;
  localparam int ACT_LOW_BASE  = 16;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
  } msg_req_t;
endpackage

// File: rtl/irq_chan.sv
module irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  input  logic msg_en,
  input  logic fire,
  input  logic clr,
  output logic status,
  output logic line_act
);
  logic stat_q, pulse_q, msg_q;
  logic msg_rise, wire_fire;

  assign msg_rise  = msg_en && !msg_q;
  assign wire_fire = fire && !msg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      msg_q <= msg_en;
      if (!en || msg_rise) begin
        stat_q  <= 1'b0;
        pulse_q <= 1'b0;
      end else if (wire_fire) begin
        stat_q  <= level;
        pulse_q <= !level;
      end else begin
        pulse_q <= 1'b0;
        if (clr) stat_q <= 1'b0;
      end
    end
  end

  assign status   = stat_q;
  assign line_act = stat_q || pulse_q;
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb #(
  parameter int N_CH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CH-1:0]              fire_msg,
  input  logic [N_CH-1:0]              keep,
  input  logic [N_CH-1:0][63:0]        word,
  output logic                         valid,
  input  logic                         ready,
  output irq_pkg::msg_req_t            req
);
  logic [N_CH-1:0] pend_q, cand, grant;
  logic            load, any;
  irq_pkg::msg_req_t req_q, pick;
  logic            valid_q;

  assign cand = (pend_q | fire_msg) & keep;
  assign load = !valid_q || ready;

  always_comb begin
    grant = '0;
    any   = 1'b0;
    pick  = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (cand[i] && !any) begin
        any      = 1'b1;
        grant[i] = 1'b1;
        pick     = '{addr: word[i][63:32], data: word[i][31:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      valid_q <= 1'b0;
      req_q   <= '0;
    end else begin
      if (load) begin
        pend_q  <= cand & ~grant;
        valid_q <= any;
        if (any) req_q <= pick;
      end else begin
        pend_q <= cand;
      end
    end
  end

  assign valid = valid_q;
  assign req   = req_q;
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map #(
  parameter int N_CH    = 4,
  parameter int N_LINES = 24,
  parameter int ROUTE_W = 5
) (
  input  logic [N_CH-1:0]              line_act,
  input  logic [N_CH-1:0]              msg_en,
  input  logic [N_CH-1:0][ROUTE_W-1:0] route,
  input  logic                         legacy,
  input  logic                         pit_lvl,
  input  logic                         rtc_lvl,
  output logic [N_LINES-1:0]           lines
);
  import irq_pkg::*;

  logic [N_LINES-1:0] asserted;

  function automatic int eff_route(input int ch, input logic leg,
                                   input logic [ROUTE_W-1:0] r);
    if (leg && ch == 0) return LEGACY_LINE_A;
    if (leg && ch == 1) return LEGACY_LINE_B;
    return int'(r);
  endfunction

  always_comb begin
    asserted = '0;
    for (int l = 0; l < N_LINES; l++) begin
      for (int i = 0; i < N_CH; i++) begin
        if (line_act[i] && !msg_en[i] && eff_route(i, legacy, route[i]) == l)
          asserted[l] = 1'b1;
      end
    end
    if (!legacy) begin
      if (pit_lvl) asserted[LEGACY_LINE_A] = 1'b1;
      if (rtc_lvl) asserted[LEGACY_LINE_B] = 1'b1;
    end
  end

  for (genvar l = 0; l < N_LINES; l++) begin : g_pol
    if (l >= ACT_LOW_BASE) begin : g_lo
      assign lines[l] = !asserted[l];
    end else begin : g_hi
      assign lines[l] = asserted[l];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_CH    = 4,
  parameter int N_LINES = 24,
  parameter int ROUTE_W = $clog2(N_LINES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         glb_en,
  input  logic                         legacy_on,
  input  logic [N_CH-1:0]              ch_en,
  input  logic [N_CH-1:0]              ch_level,
  input  logic [N_CH-1:0]              ch_msg_en,
  input  logic [N_CH-1:0][ROUTE_W-1:0] ch_route,
  input  logic [N_CH-1:0][63:0]        ch_msg_word,
  input  logic [N_CH-1:0]              fire,
  input  logic                         clr_we,
  input  logic [N_CH-1:0]              clr_mask,
  input  logic                         ext_pit_in,
  input  logic                         ext_rtc_in,
  output logic [N_LINES-1:0]           irq_o,
  output logic [N_CH-1:0]              status_o,
  output logic                         pit_en_o,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic [31:0]                  msg_addr,
  output logic [31:0]                  msg_data
);
  logic [N_CH-1:0] live, line_act, fire_msg;
  logic            pit_q, rtc_q, pit_en_q;
  irq_pkg::msg_req_t req;

  assign live     = ch_en & {N_CH{glb_en}};
  assign fire_msg = fire & ch_msg_en & live;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    irq_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (live[i]),
      .level    (ch_level[i]),
      .msg_en   (ch_msg_en[i]),
      .fire     (fire[i]),
      .clr      (clr_we && clr_mask[i]),
      .status   (status_o[i]),
      .line_act (line_act[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pit_q    <= 1'b0;
      rtc_q    <= 1'b0;
      pit_en_q <= 1'b1;
    end else begin
      pit_q    <= ext_pit_in;
      rtc_q    <= ext_rtc_in;
      pit_en_q <= !legacy_on;
    end
  end
  assign pit_en_o = pit_en_q;

  irq_line_map #(.N_CH(N_CH), .N_LINES(N_LINES), .ROUTE_W(ROUTE_W)) u_map (
    .line_act (line_act),
    .msg_en   (ch_msg_en),
    .route    (ch_route),
    .legacy   (legacy_on),
    .pit_lvl  (pit_q),
    .rtc_lvl  (rtc_q),
    .lines    (irq_o)
  );

  irq_msg_arb #(.N_CH(N_CH)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_msg (fire_msg),
    .keep     (live & ch_msg_en),
    .word     (ch_msg_word),
    .valid    (msg_valid),
    .ready    (msg_ready),
    .req      (req)
  );
  assign msg_addr = req.addr;
  assign msg_data = req.data;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_CH    = 4,
  parameter int N_LINES = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_en,
  input logic               legacy_on,
  input logic [N_CH-1:0]    ch_en,
  input logic [N_CH-1:0]    ch_level,
  input logic [N_CH-1:0]    ch_msg_en,
  input logic [N_CH-1:0]    fire,
  input logic [N_CH-1:0]    clr_mask,
  input logic               clr_we,
  input logic [N_CH-1:0]    status_o,
  input logic               pit_en_o,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [31:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [N_LINES-1:0] irq_o
);
  logic [N_CH-1:0] lvl_fire, edge_fire, msg_fire, w1c;
  assign lvl_fire  = fire & ch_level & ~ch_msg_en & ch_en & {N_CH{glb_en}};
  assign edge_fire = fire & ~ch_level;
  assign msg_fire  = fire & ch_msg_en;
  assign w1c       = {N_CH{clr_we}} & clr_mask & status_o & ~fire;

  a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_fire) |=> ((status_o & $past(lvl_fire)) == $past(lvl_fire)));
  a_r3_edge_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_fire) |=> ((status_o & $past(edge_fire)) == '0));
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (|w1c) |=> ((status_o & $past(w1c)) == '0));
  a_r7_msg_no_status: assert property (@(posedge clk) disable iff (!rst_n)
    (|msg_fire) |=> ((status_o & $past(msg_fire)) == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
  a_r9_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (status_o == '0));
  a_r12_pit_en: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_on |=> !pit_en_o);
  a_r12_pit_en_back: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy_on |=> pit_en_o);
  always_comb begin
    if (rst_n && N_LINES > 16) assert (^irq_o === 1'b0 || ^irq_o === 1'b1);
  end
endmodule

bind irq_router irq_router_chk #(.N_CH(N_CH), .N_LINES(N_LINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_en    (glb_en),
  .legacy_on (legacy_on),
  .ch_en     (ch_en),
  .ch_level  (ch_level),
  .ch_msg_en (ch_msg_en),
  .fire      (fire),
  .clr_mask  (clr_mask),
  .clr_we    (clr_we),
  .status_o  (status_o),
  .pit_en_o  (pit_en_o),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .irq_o     (irq_o)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NC = 4;
  localparam int NL = 24;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b1, legacy_on = 1'b0;
  logic [NC-1:0] ch_en = '1, ch_level = '1, ch_msg_en = '0, fire = '0, clr_mask = '0;
  logic [NC-1:0][RW-1:0] ch_route;
  logic [NC-1:0][63:0] ch_msg_word;
  logic clr_we = 1'b0, ext_pit_in = 1'b0, ext_rtc_in = 1'b0, msg_ready = 1'b0;
  logic [NL-1:0] irq_o;
  logic [NC-1:0] status_o;
  logic pit_en_o, msg_valid;
  logic [31:0] msg_addr, msg_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_router u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic fire_ch(input int c);
    fire[c] = 1'b1;
    tick();
    fire[c] = 1'b0;
  endtask

  task automatic clear_ch(input int c);
    clr_we = 1'b1; clr_mask = '0; clr_mask[c] = 1'b1;
    tick();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 0);
    chk("R1 lines", irq_o, 24'hFF0000);
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 pit_en", pit_en_o, 1);
  endtask

  task automatic t_level();
    fire_ch(0);
    chk("R2 status set", status_o, 4'b0001);
    chk("R2 line3", irq_o[3], 1);
    tick();
    chk("R2 held", irq_o[3], 1);
    clr_we = 1'b1; clr_mask = 4'b0000; tick(); clr_we = 1'b0;
    chk("R4 zero mask no effect", status_o, 4'b0001);
    clear_ch(0);
    chk("R4 cleared", status_o, 0);
    chk("R4 line3 low", irq_o[3], 0);
  endtask

  task automatic t_edge();
    ch_level[1] = 1'b0;
    fire_ch(1);
    chk("R3 pulse high", irq_o[5], 1);
    chk("R3 no status", status_o[1], 0);
    tick();
    chk("R3 pulse one cycle", irq_o[5], 0);
    ch_level[1] = 1'b1;
  endtask

  task automatic t_actlo();
    fire_ch(2);
    chk("R5 line17 asserted low", irq_o[17], 0);
    clear_ch(2);
    chk("R5 line17 idle high", irq_o[17], 1);
  endtask

  task automatic t_same();
    fire_ch(0);
    fire[0] = 1'b1; clr_we = 1'b1; clr_mask = 4'b0001;
    tick();
    fire[0] = 1'b0; clr_we = 1'b0; clr_mask = '0;
    chk("R13 fire wins", status_o[0], 1);
    clear_ch(0);
  endtask

  task automatic t_disable();
    fire_ch(0);
    ch_en[0] = 1'b0; tick();
    chk("R9 ch disable clears", status_o[0], 0);
    chk("R9 line3 low", irq_o[3], 0);
    fire_ch(0);
    chk("R9 fire ignored", irq_o[3], 0);
    ch_en[0] = 1'b1;
    fire_ch(3);
    chk("R9 ch3 set", irq_o[20], 0);
    glb_en = 1'b0; tick();
    chk("R9 global off clears", status_o, 0);
    chk("R9 line20 idle", irq_o[20], 1);
    glb_en = 1'b1;
  endtask

  task automatic t_msg();
    fire_ch(2);
    ch_msg_en[2] = 1'b1; tick();
    chk("R10 msg_en rise clears", status_o[2], 0);
    chk("R10 line17 idle", irq_o[17], 1);
    fire_ch(2);
    chk("R7 valid", msg_valid, 1);
    chk("R7 addr", msg_addr, 32'hA000_0004);
    chk("R7 data", msg_data, 32'h1234_5678);
    chk("R7 no line", irq_o[17], 1);
    chk("R7 no status", status_o[2], 0);
    ch_msg_en[3] = 1'b1; tick();
    fire_ch(3); fire_ch(3);
    chk("R8 held addr", msg_addr, 32'hA000_0004);
    msg_ready = 1'b1; tick();
    chk("R8 next is ch3", msg_data, 32'hCAFE_0003);
    chk("R8 still valid", msg_valid, 1);
    tick();
    chk("R8 merged to one", msg_valid, 0);
    msg_ready = 1'b0;
    fire = 4'b1100; tick(); fire = '0;
    chk("R8 lowest first", msg_data, 32'h1234_5678);
    msg_ready = 1'b1; tick();
    chk("R8 then ch3", msg_data, 32'hCAFE_0003);
    tick();
    chk("R8 drained", msg_valid, 0);
    msg_ready = 1'b0;
    ch_msg_en = '0; tick();
  endtask

  task automatic t_legacy();
    ext_pit_in = 1'b1; tick();
    chk("R11 pit pass", irq_o[0], 1);
    ext_rtc_in = 1'b1; tick();
    chk("R11 rtc pass", irq_o[8], 1);
    legacy_on = 1'b1; tick();
    chk("R12 pit_en low", pit_en_o, 0);
    chk("R12 line0 low", irq_o[0], 0);
    chk("R12 line8 low", irq_o[8], 0);
    fire_ch(0);
    chk("R6 ch0 to line0", irq_o[0], 1);
    chk("R6 route3 unused", irq_o[3], 0);
    clear_ch(0);
    ch_level[1] = 1'b0;
    fire_ch(1);
    chk("R6 ch1 to line8", irq_o[8], 1);
    chk("R6 route5 unused", irq_o[5], 0);
    ch_level[1] = 1'b1;
    ext_pit_in = 1'b0;
    legacy_on = 1'b0; tick();
    chk("R12 pit_en back", pit_en_o, 1);
    chk("R12 line8 restored", irq_o[8], 1);
    chk("R12 line0 low", irq_o[0], 0);
    ext_rtc_in = 1'b0; tick();
  endtask

  initial begin
    ch_route[0] = 5'd3;  ch_route[1] = 5'd5;
    ch_route[2] = 5'd17; ch_route[3] = 5'd20;
    ch_msg_word[0] = 64'h0;
    ch_msg_word[1] = 64'h0;
    ch_msg_word[2] = 64'hA000_0004_1234_5678;
    ch_msg_word[3] = 64'hB000_0008_CAFE_0003;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_level();
    t_edge();
    t_actlo();
    t_same();
    t_disable();
    t_msg();
    t_legacy();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule